// File: doc/BRIEF.md
# Conditional Relative Branch Evaluator

This block settles the control-flow outcome of a relative jump instruction. It takes a 4-bit condition select, the contents of a general-purpose register that an earlier compare filled with condition bits, the current program counter and a 16-bit offset. It reports whether the jump is taken and gives the program counter of the next instruction. An unconditional relative jump uses the same path: the `is_jump` input forces the jump to be taken whatever the select and the register hold.

The condition bits sit in an ordinary register and not in a dedicated flags register. Their layout is bit 0 carry, bit 1 borrow, bit 2 overflow, bit 3 greater, bit 4 equal and bit 5 less. Bits above 5 play a part only in the zero and not-zero tests, which examine the whole register. The offset is sign-extended to the program counter width. A jump that is not taken moves on by the fixed instruction size of 4 bytes.

The `OUT_REG` parameter selects how the outputs are produced. With the default value of 1, the outputs are registered and appear one clock after `in_valid`. With a value of 0, they follow the inputs combinationally.

Top module: `brc_branch_unit`

## Requirements
- R1: Select 0 is taken when register bit 0 (carry) is set. Select 1 is taken on bit 1 (borrow), select 2 on bit 2 (overflow) and select 3 on bit 3 (greater).
- R2: Select 4 (greater-or-equal) is taken when bit 3 or bit 4 is set. Select 7 (less-or-equal) is taken when bit 5 or bit 4 is set.
- R3: Select 5 (equal) is taken when bit 4 is set. Select 6 (not-equal) is taken when bit 4 is clear. Select 8 (less) is taken when bit 5 is set.
- R4: Select 9 is taken when the whole register is zero. Select 10 (0xA) is taken when any bit of the register is set.
- R5: When the jump is taken, `next_pc` equals `pc` plus the sign-extended offset, modulo 2^PC_W.
- R6: When the jump is not taken, `next_pc` equals `pc` plus 4, modulo 2^PC_W.
- R7: Selects 11 to 15 (0xB to 0xF) are reserved. A reserved select is never taken, drives `illegal` to 1 and gives `next_pc` = `pc` + 4. For every other select, `illegal` is 0.
- R8: With `is_jump` at 1, the jump is taken and `illegal` is 0, whatever `cond_sel` and `cond_reg` hold.
- R9: With the registered output, results appear with `out_valid` one clock after `in_valid` is sampled at 1. While `in_valid` is 0, `next_pc`, `taken` and `illegal` hold their values and `out_valid` is 0. Reset clears all four outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs carry a jump to evaluate |
| is_jump | input | 1 | Unconditional relative jump |
| cond_sel | input | 4 | Condition select |
| cond_reg | input | XLEN (32) | Register holding the condition bits |
| pc | input | PC_W (32) | Current program counter |
| offset | input | OFF_W (16) | Signed relative offset |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | The jump is taken |
| illegal | output | 1 | A reserved select was used |
| next_pc | output | PC_W (32) | Program counter of the next instruction |

## Verification
A wrong bit position or a wrong OR term in the condition decode appears in `taken` on the first result after the faulty pattern. It also appears in `next_pc` on that same result, which then misses by the offset minus 4. For this reason, every select is swept against all 64 patterns of the six condition bits, and also against patterns that use only the upper bits. A slip in sign extension or in the result register is seen one clock after the request, when offsets on both sides of the sign boundary are applied and the program counter is taken across its wrap point.

// File: rtl/brc_pkg.sv
package brc_pkg;
   typedef enum logic [3:0] {
      SEL_CARRY  = 4'h0,
      SEL_BORROW = 4'h1,
      SEL_OVFL   = 4'h2,
      SEL_GT     = 4'h3,
      SEL_GE     = 4'h4,
      SEL_EQ     = 4'h5,
      SEL_NE     = 4'h6,
      SEL_LE     = 4'h7,
      SEL_LT     = 4'h8,
      SEL_ZERO   = 4'h9,
      SEL_NZERO  = 4'hA
   } cond_sel_e;

   localparam int FLAG_CARRY  = 0;
   localparam int FLAG_BORROW = 1;
   localparam int FLAG_OVFL   = 2;
   localparam int FLAG_GT     = 3;
   localparam int FLAG_EQ     = 4;
   localparam int FLAG_LT     = 5;
   localparam int FLAG_COUNT  = 6;

   localparam logic [3:0] SEL_LAST_LEGAL = 4'hA;
endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
   import brc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [3:0]      sel,
   input  logic [XLEN-1:0] flags,
   output logic            cond_true,
   output logic            reserved
);
   initial begin
      if (XLEN < FLAG_COUNT) $error("XLEN too small for condition bits");
   end

   logic reg_is_zero;
   assign reg_is_zero = (flags == '0);

   always_comb begin
      cond_true = 1'b0;
      reserved  = 1'b0;
      case (sel)
         SEL_CARRY:  cond_true = flags[FLAG_CARRY];
         SEL_BORROW: cond_true = flags[FLAG_BORROW];
         SEL_OVFL:   cond_true = flags[FLAG_OVFL];
         SEL_GT:     cond_true = flags[FLAG_GT];
         SEL_GE:     cond_true = flags[FLAG_GT] | flags[FLAG_EQ];
         SEL_EQ:     cond_true = flags[FLAG_EQ];
         SEL_NE:     cond_true = ~flags[FLAG_EQ];
         SEL_LE:     cond_true = flags[FLAG_LT] | flags[FLAG_EQ];
         SEL_LT:     cond_true = flags[FLAG_LT];
         SEL_ZERO:   cond_true = reg_is_zero;
         SEL_NZERO:  cond_true = ~reg_is_zero;
         default:    reserved  = 1'b1;
      endcase
   end

   always_comb begin
      AST_RESERVED_FALSE: assert (!(reserved && cond_true)); // R7
   end
endmodule

// File: rtl/brc_target.sv
module brc_target #(
   parameter int PC_W  = 32,
   parameter int OFF_W = 16,
   parameter int STEP  = 4
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [OFF_W-1:0] offset,
   input  logic             take,
   output logic [PC_W-1:0]  target
);
   localparam int EXT_W = PC_W - OFF_W;
   localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

   initial begin
      if (PC_W < OFF_W) $error("PC_W must be at least OFF_W");
      if (STEP < 1)     $error("STEP must be positive");
   end

   logic [PC_W-1:0] off_ext;

   generate
      if (EXT_W > 0) begin : g_sext
         assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
      end else begin : g_same
         assign off_ext = offset;
      end
   endgenerate

   logic [PC_W-1:0] jump_pc;
   logic [PC_W-1:0] seq_pc;
   assign jump_pc = pc + off_ext;
   assign seq_pc  = pc + STEP_V;
   assign target  = take ? jump_pc : seq_pc;
endmodule

// File: rtl/brc_branch_unit.sv
module brc_branch_unit #(
   parameter int XLEN    = 32,
   parameter int PC_W    = 32,
   parameter int OFF_W   = 16,
   parameter int STEP    = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             is_jump,
   input  logic [3:0]       cond_sel,
   input  logic [XLEN-1:0]  cond_reg,
   input  logic [PC_W-1:0]  pc,
   input  logic [OFF_W-1:0] offset,
   output logic             out_valid,
   output logic             taken,
   output logic             illegal,
   output logic [PC_W-1:0]  next_pc
);
   localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

   logic cond_true, sel_reserved, take_c, illegal_c;
   logic [PC_W-1:0] target_c;

   brc_cond_eval #(.XLEN(XLEN)) u_cond (
      .sel       (cond_sel),
      .flags     (cond_reg),
      .cond_true (cond_true),
      .reserved  (sel_reserved)
   );

   assign take_c    = is_jump | cond_true;
   assign illegal_c = ~is_jump & sel_reserved;

   brc_target #(.PC_W(PC_W), .OFF_W(OFF_W), .STEP(STEP)) u_tgt (
      .pc     (pc),
      .offset (offset),
      .take   (take_c),
      .target (target_c)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               taken     <= 1'b0;
               illegal   <= 1'b0;
               next_pc   <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  taken   <= take_c;
                  illegal <= illegal_c;
                  next_pc <= target_c;
               end
            end
         end

         AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R9
         AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(next_pc) && $stable(taken) && !out_valid)); // R9
         AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && is_jump) |=> (taken && !illegal)); // R8
         AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !is_jump && sel_reserved) |=> (next_pc == $past(pc) + STEP_V)); // R7
         AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
            illegal |-> !taken); // R7
      end else begin : g_comb
         assign out_valid = in_valid;
         assign taken     = take_c;
         assign illegal   = illegal_c;
         assign next_pc   = target_c;
      end
   endgenerate
endmodule

// File: tb/brc_branch_unit_tb.sv
module brc_branch_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        is_jump = 1'b0;
   logic [3:0]  cond_sel = '0;
   logic [31:0] cond_reg = '0;
   logic [31:0] pc = '0;
   logic [15:0] offset = '0;
   logic        out_valid, taken, illegal;
   logic [31:0] next_pc;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   brc_branch_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_jump(is_jump),
      .cond_sel(cond_sel), .cond_reg(cond_reg), .pc(pc), .offset(offset),
      .out_valid(out_valid), .taken(taken), .illegal(illegal), .next_pc(next_pc)
   );

   function automatic bit exp_take(input bit j, input logic [3:0] s, input logic [31:0] r);
      if (j) return 1'b1;
      case (s)
         4'h0: return r[0];
         4'h1: return r[1];
         4'h2: return r[2];
         4'h3: return r[3];
         4'h4: return r[3] | r[4];
         4'h5: return r[4];
         4'h6: return !r[4];
         4'h7: return r[5] | r[4];
         4'h8: return r[5];
         4'h9: return r == 0;
         4'hA: return r != 0;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string tag_of(input bit j, input logic [3:0] s);
      if (j) return "R8";
      if (s <= 4'h3) return "R1";
      if (s == 4'h4 || s == 4'h7) return "R2";
      if (s == 4'h5 || s == 4'h6 || s == 4'h8) return "R3";
      if (s == 4'h9 || s == 4'hA) return "R4";
      return "R7";
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic run(input bit j, input logic [3:0] s, input logic [31:0] r,
                      input logic [31:0] p, input logic [15:0] o);
      bit t;
      logic [31:0] npc;
      @(negedge clk);
      in_valid = 1'b1; is_jump = j; cond_sel = s; cond_reg = r; pc = p; offset = o;
      @(negedge clk);
      t = exp_take(j, s, r);
      npc = t ? p + {{16{o[15]}}, o} : p + 32'd4;
      chk({tag_of(j, s), " taken"}, {31'd0, taken}, {31'd0, t});
      chk({tag_of(j, s), " illegal R7"}, {31'd0, illegal}, {31'd0, (!j && s > 4'hA)});
      chk(t ? "R5 next_pc" : "R6 next_pc", next_pc, npc);
      chk("R9 out_valid", {31'd0, out_valid}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset out_valid", {31'd0, out_valid}, 32'd0);
      chk("R9 reset taken", {31'd0, taken}, 32'd0);
      chk("R9 reset illegal", {31'd0, illegal}, 32'd0);
      chk("R9 reset next_pc", next_pc, 32'd0);
      rst_n = 1'b1;

      for (int s = 0; s < 16; s++) begin
         for (int f = 0; f < 64; f++)
            run(1'b0, 4'(s), 32'(f), 32'h0000_1000 + 32'(f * 8), 16'h0040);
         run(1'b0, 4'(s), 32'h8000_0000, 32'h0000_2000, 16'hFFF0);
         run(1'b0, 4'(s), 32'h0000_0040, 32'h0000_2000, 16'h0010);
      end

      run(1'b0, 4'h6, 32'h0, 32'hFFFF_FFFC, 16'h7FFF);
      run(1'b0, 4'h6, 32'h0, 32'h0000_0004, 16'h8000);
      run(1'b0, 4'h6, 32'h0, 32'h0000_0010, 16'hFFFF);
      run(1'b0, 4'h5, 32'h0, 32'hFFFF_FFFC, 16'h1234);
      run(1'b0, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 16'h0100);

      for (int s = 0; s < 16; s++) begin
         run(1'b1, 4'(s), 32'h0, 32'h0000_3000, 16'hFF00);
         run(1'b1, 4'(s), 32'hFFFF_FFFF, 32'h7FFF_FFF0, 16'h0020);
      end

      // R9: idle cycles hold results and drop out_valid
      run(1'b0, 4'h0, 32'h1, 32'h0000_5000, 16'h0100);
      @(negedge clk);
      in_valid = 1'b0; pc = 32'h0000_9000; cond_sel = 4'hC;
      @(negedge clk);
      @(negedge clk);
      chk("R9 idle out_valid", {31'd0, out_valid}, 32'd0);
      chk("R9 idle next_pc", next_pc, 32'h0000_5100);
      chk("R9 idle taken", {31'd0, taken}, 32'd1);
      chk("R9 idle illegal", {31'd0, illegal}, 32'd0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule